// File: doc/BRIEF.md
# Unsigned N-Step Non-Restoring Divider

This block divides a 32-bit unsigned divisor into a 32-bit dividend that the caller has already shifted left by the step count N. It runs N non-restoring add/subtract steps, one per clock, and then spends one more cycle on a restoring correction of the remainder. The result is a 32-bit quotient, a 32-bit remainder and an overflow flag. The flag is raised for a zero divisor and for a quotient that does not fit. Both conditions are found inside the iteration, from the carry and the sign of each step, and not by a separate compare.

A 4-bit step selector sets N to 32 minus twice its value, so N is even and lies between 2 and 32. A halfword mode takes only the low 16 bits of the divisor, zero-extended. The caller pulses `start_i` while the block is idle. `busy_o` stays high for the whole operation. `done_o` pulses once when the results are ready, and the results are held until the next operation completes.

Top module: `nsdiv_unsigned`

## Requirements
- R1: After reset `busy_o` and `done_o` are 0 and `quotient_o`, `remainder_o` and `overflow_o` are all 0.
- R2: The step count is N = 32 - 2*`steps_sel_i`. `steps_sel_i` = 0 gives N = 32 and `steps_sel_i` = 15 gives N = 2. It is sampled in the cycle the start is accepted.
- R3: A start accepted at clock edge A makes `done_o` read 1 just after edge A+N+1. `busy_o` is 1 from edge A until that edge and 0 while `done_o` is 1.
- R4: `done_o` is high for exactly one cycle. `quotient_o`, `remainder_o` and `overflow_o` change only in the cycle in which `done_o` rises, and otherwise hold their values.
- R5: A start that arrives while `busy_o` is 1 is ignored. The running operation finishes with its original operands and its original latency.
- R6: The quotient follows the step rules exactly. The partial remainder starts as the dividend shifted right by N-1, with operation bit q = 1 and previous sign 0. Each step adds the inverted divisor plus 1 when q = 1, and adds the divisor when q = 0. The corrected carry is the carry-out XOR q, and the new q is NOT(corrected carry XOR previous sign). The new q enters bit 0 of the quotient register, which is first shifted left by 33-N on step 1 and by 1 on later steps. The next partial remainder is the sum shifted left by one, with the quotient register MSB entering at bit 0. On the last step the register is left as it is, and the final quotient is that register shifted left by one with the last q in bit 0.
- R7: The remainder is the last sum when the last q is 1, and the last sum plus the divisor when the last q is 0.
- R8: A zero divisor (after halfword masking) always gives `overflow_o` = 1.
- R9: `overflow_o` = Z OR F. Z starts at 1 for a zero divisor and is set whenever a step's sum MSB differs from the previous sign while the corrected carry is 0. F starts at 1 and after every step becomes 0 if the sum is zero, and otherwise F AND the new q.
- R10: With `half_i` = 1, bits 31..16 of `divisor_i` have no effect on any output.
- R11: With N = 32, a nonzero divisor below 2^16 and a dividend below 2^31, the quotient and remainder equal the integer quotient and remainder and `overflow_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken only when idle |
| half_i | input | 1 | 1: use only the low 16 bits of the divisor |
| steps_sel_i | input | 4 | Step selector, N = 32 - 2*value |
| divisor_i | input | 32 | Divisor |
| dividend_i | input | 32 | Dividend, already shifted left by N |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse when results are ready |
| quotient_o | output | 32 | Quotient |
| remainder_o | output | 32 | Remainder |
| overflow_o | output | 1 | Zero divisor or quotient out of range |

## Verification
A single wrong step in the partial remainder, the q bit or the quotient register does not show up until `done_o` pulses N+1 cycles after the start. It then appears as a wrong quotient bit, or as a remainder that is wrong by the divisor. A wrongly set or wrongly cleared Z or F flag shows up at the same moment, as a wrong `overflow_o`. A counter or sequencing fault moves `done_o` away from cycle N+1, so the latency is measured on every operation. Starts injected while busy, and halfword divisors whose upper bits are random, show whether a stray register load reaches the ports at completion.

// File: rtl/nsdiv_pkg.sv
package nsdiv_pkg;

  localparam int NSD_W  = 32;
  localparam int NSD_FW = 4;
  localparam int NSD_HW = 16;
  localparam int NSD_CW = $clog2(NSD_W + 2);

  typedef enum logic [1:0] {
    NSD_IDLE = 2'd0,
    NSD_STEP = 2'd1,
    NSD_FIN  = 2'd2
  } nsd_state_e;

  typedef struct packed {
    logic [NSD_W-1:0] sum;
    logic             q;
    logic             s;
    logic             fit;
    logic             dbz;
  } nsd_step_t;

  function automatic logic [NSD_CW-1:0] nsd_steps(input logic [NSD_FW-1:0] sel);
    logic [NSD_CW-1:0] twice;
    twice = NSD_CW'({sel, 1'b0});
    return NSD_CW'(NSD_W) - twice;
  endfunction

  function automatic nsd_step_t nsd_step(input logic [NSD_W-1:0] prem,
                                         input logic [NSD_W-1:0] dvs,
                                         input logic qb, input logic sb,
                                         input logic fit, input logic dbz);
    nsd_step_t        r;
    logic [NSD_W-1:0] addend;
    logic             cy;
    logic             cc;
    logic             nq;
    addend = qb ? ~dvs : dvs;
    r.sum  = prem + addend + {{(NSD_W-1){1'b0}}, qb};
    cy     = (addend[NSD_W-1] & prem[NSD_W-1]) |
             ((addend[NSD_W-1] ^ prem[NSD_W-1]) & ~r.sum[NSD_W-1]);
    cc     = cy ^ qb;
    nq     = ~(cc ^ sb);
    r.q    = nq;
    r.s    = r.sum[NSD_W-1];
    r.fit  = (r.sum == '0) ? 1'b0 : (fit & nq);
    r.dbz  = dbz | ((sb ^ r.sum[NSD_W-1]) & ~cc);
    return r;
  endfunction

  function automatic logic [NSD_W-1:0] nsd_remfix(input logic [NSD_W-1:0] sum,
                                                  input logic [NSD_W-1:0] dvs,
                                                  input logic qb);
    return qb ? sum : (sum + dvs);
  endfunction

endpackage

// File: rtl/nsdiv_step.sv
module nsdiv_step
  import nsdiv_pkg::*;
(
  input  logic [NSD_W-1:0] prem_i,
  input  logic [NSD_W-1:0] dvs_i,
  input  logic             qb_i,
  input  logic             sb_i,
  input  logic             fit_i,
  input  logic             dbz_i,
  output nsd_step_t        res_o
);

  always_comb begin
    res_o = nsd_step(prem_i, dvs_i, qb_i, sb_i, fit_i, dbz_i);
  end

endmodule

// File: rtl/nsdiv_ctrl.sv
module nsdiv_ctrl
  import nsdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [NSD_CW-1:0] n_new_i,
  output logic              busy_o,
  output logic              load_o,
  output logic              step_en_o,
  output logic              first_o,
  output logic              last_o,
  output logic              fin_o,
  output logic              done_o,
  output logic [NSD_CW-1:0] n_cur_o
);

  nsd_state_e        state_q, state_d;
  logic [NSD_CW-1:0] cnt_q;
  logic [NSD_CW-1:0] n_q;
  logic              done_q;

  always_comb begin
    load_o    = start_i && (state_q == NSD_IDLE);
    step_en_o = (state_q == NSD_STEP);
    first_o   = step_en_o && (cnt_q == '0);
    last_o    = step_en_o && (cnt_q == (n_q - NSD_CW'(1)));
    fin_o     = (state_q == NSD_FIN);
    busy_o    = (state_q != NSD_IDLE);
    done_o    = done_q;
    n_cur_o   = n_q;
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      NSD_IDLE: if (load_o) state_d = NSD_STEP;
      NSD_STEP: if (last_o) state_d = NSD_FIN;
      NSD_FIN:  state_d = NSD_IDLE;
      default:  state_d = NSD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= NSD_IDLE;
      cnt_q   <= '0;
      n_q     <= NSD_CW'(NSD_W);
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= fin_o;
      if (load_o) begin
        cnt_q <= '0;
        n_q   <= n_new_i;
      end else if (step_en_o) begin
        cnt_q <= cnt_q + NSD_CW'(1);
      end
    end
  end

  // R4: completion strobe lasts a single cycle
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R3: the block is idle while reporting completion
  p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R3: the step counter never runs past the latched step count
  p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step_en_o |-> (cnt_q < n_q));

  // R3: the correction cycle follows the last step directly
  p_fin_after_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> fin_o);

endmodule

// File: rtl/nsdiv_dpath.sv
module nsdiv_dpath
  import nsdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              step_en_i,
  input  logic              first_i,
  input  logic              last_i,
  input  logic              fin_i,
  input  logic [NSD_CW-1:0] n_new_i,
  input  logic [NSD_CW-1:0] n_cur_i,
  input  logic [NSD_W-1:0]  dividend_i,
  input  logic [NSD_W-1:0]  dvs_i,
  output logic [NSD_W-1:0]  quotient_o,
  output logic [NSD_W-1:0]  remainder_o,
  output logic              overflow_o,
  output logic [NSD_W-1:0]  dvs_cur_o
);

  logic [NSD_W-1:0]  pr_q;
  logic [NSD_W-1:0]  qr_q;
  logic [NSD_W-1:0]  dvs_q;
  logic              qb_q, sb_q, fit_q, dbz_q;
  logic [NSD_W-1:0]  quo_q, rem_q;
  logic              ovf_q;
  nsd_step_t         res;
  logic [NSD_CW-1:0] first_sh;
  logic [NSD_W-1:0]  qr_next;

  nsdiv_step u_step (
    .prem_i (pr_q),
    .dvs_i  (dvs_q),
    .qb_i   (qb_q),
    .sb_i   (sb_q),
    .fit_i  (fit_q),
    .dbz_i  (dbz_q),
    .res_o  (res)
  );

  always_comb begin
    first_sh = NSD_CW'(NSD_W + 1) - n_cur_i;
    if (first_i) qr_next = (qr_q << first_sh) | {{(NSD_W-1){1'b0}}, res.q};
    else         qr_next = {qr_q[NSD_W-2:0], res.q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pr_q  <= '0;
      qr_q  <= '0;
      dvs_q <= '0;
      qb_q  <= 1'b1;
      sb_q  <= 1'b0;
      fit_q <= 1'b1;
      dbz_q <= 1'b0;
      quo_q <= '0;
      rem_q <= '0;
      ovf_q <= 1'b0;
    end else if (load_i) begin
      pr_q  <= dividend_i >> (n_new_i - NSD_CW'(1));
      qr_q  <= dividend_i;
      dvs_q <= dvs_i;
      qb_q  <= 1'b1;
      sb_q  <= 1'b0;
      fit_q <= 1'b1;
      dbz_q <= (dvs_i == '0);
    end else if (step_en_i) begin
      qb_q  <= res.q;
      sb_q  <= res.s;
      fit_q <= res.fit;
      dbz_q <= res.dbz;
      if (last_i) begin
        pr_q <= res.sum;
      end else begin
        pr_q <= {res.sum[NSD_W-2:0], qr_next[NSD_W-1]};
        qr_q <= qr_next;
      end
    end else if (fin_i) begin
      quo_q <= {qr_q[NSD_W-2:0], qb_q};
      rem_q <= nsd_remfix(pr_q, dvs_q, qb_q);
      ovf_q <= dbz_q | fit_q;
    end
  end

  assign quotient_o  = quo_q;
  assign remainder_o = rem_q;
  assign overflow_o  = ovf_q;
  assign dvs_cur_o   = dvs_q;

  // R9: the divide-by-zero/overflow flag is sticky within an operation
  p_dbz_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dbz_q && !load_i) |=> dbz_q);

  // R8: a zero divisor arms the flag at load time
  p_zero_arms_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && (dvs_i == '0)) |=> dbz_q);

endmodule

// File: rtl/nsdiv_unsigned.sv
module nsdiv_unsigned
  import nsdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              half_i,
  input  logic [NSD_FW-1:0] steps_sel_i,
  input  logic [NSD_W-1:0]  divisor_i,
  input  logic [NSD_W-1:0]  dividend_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [NSD_W-1:0]  quotient_o,
  output logic [NSD_W-1:0]  remainder_o,
  output logic              overflow_o
);

  localparam logic [NSD_W-1:0] HALF_MASK = {{(NSD_W-NSD_HW){1'b0}}, {NSD_HW{1'b1}}};

  logic              load, step_en, first_step, last_step, fin;
  logic [NSD_CW-1:0] n_new, n_cur;
  logic [NSD_W-1:0]  dvs_sel;
  logic [NSD_W-1:0]  dvs_cur;

  always_comb begin
    n_new   = nsd_steps(steps_sel_i);
    dvs_sel = half_i ? (divisor_i & HALF_MASK) : divisor_i;
  end

  nsdiv_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .n_new_i   (n_new),
    .busy_o    (busy_o),
    .load_o    (load),
    .step_en_o (step_en),
    .first_o   (first_step),
    .last_o    (last_step),
    .fin_o     (fin),
    .done_o    (done_o),
    .n_cur_o   (n_cur)
  );

  nsdiv_dpath u_dpath (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load),
    .step_en_i   (step_en),
    .first_i     (first_step),
    .last_i      (last_step),
    .fin_i       (fin),
    .n_new_i     (n_new),
    .n_cur_i     (n_cur),
    .dividend_i  (dividend_i),
    .dvs_i       (dvs_sel),
    .quotient_o  (quotient_o),
    .remainder_o (remainder_o),
    .overflow_o  (overflow_o),
    .dvs_cur_o   (dvs_cur)
  );

  // R8: completing with a zero divisor always reports overflow
  p_zero_div_ovf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && (dvs_cur == '0)) |-> overflow_o);

  // R4: results move only together with the completion strobe
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(quotient_o) && $stable(remainder_o) && $stable(overflow_o)));

  // R5: a start during an operation does not reload the divisor
  p_start_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(dvs_cur));

  // R10: in halfword mode the captured divisor has no upper bits
  p_half_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (load && half_i) |=> (dvs_cur[NSD_W-1:NSD_HW] == '0));

endmodule

// File: tb/tb_nsdiv_unsigned.sv
`timescale 1ns/1ps
module tb_nsdiv_unsigned;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        half = 1'b0;
  logic [3:0]  sel = 4'd0;
  logic [31:0] dvs = 32'd0;
  logic [31:0] dvd = 32'd0;
  logic        busy, done, ovf;
  logic [31:0] quo, rem;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  nsdiv_unsigned dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .half_i(half),
    .steps_sel_i(sel), .divisor_i(dvs), .dividend_i(dvd),
    .busy_o(busy), .done_o(done), .quotient_o(quo),
    .remainder_o(rem), .overflow_o(ovf)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      wrap_up();
    end
  end

  // Bench model of the step rules, using a 33-bit sum for the carry
  function automatic void model(input logic [31:0] x, input logic [31:0] d, input int n,
                                output logic [31:0] qo, output logic [31:0] ro,
                                output logic ov);
    logic [31:0] p, qr, last;
    logic [32:0] t;
    logic qb, sb, fit, z, cc, nq;
    p = x >> (n - 1);
    qr = x;
    qb = 1'b1; sb = 1'b0; fit = 1'b1; z = (d == 32'd0);
    last = 32'd0;
    for (int k = 1; k <= n; k++) begin
      t = {1'b0, p} + {1'b0, (qb ? ~d : d)} + {32'd0, qb};
      cc = t[32] ^ qb;
      nq = !(cc ^ sb);
      if (t[31:0] == 32'd0) fit = 1'b0; else fit = fit & nq;
      if ((sb != t[31]) && !cc) z = 1'b1;
      sb = t[31];
      if (k < n) begin
        if (k == 1) qr = (qr << (33 - n)) | {31'd0, nq};
        else        qr = {qr[30:0], nq};
        p = {t[30:0], qr[31]};
      end else begin
        last = t[31:0];
      end
      qb = nq;
    end
    qo = {qr[30:0], qb};
    ro = qb ? last : last + d;
    ov = z | fit;
  endfunction

  // Runs one operation; optional start with other operands injected while busy
  task automatic run_div(input logic [31:0] x, input logic [31:0] d, input logic [3:0] s,
                         input logic hm, input bit inject);
    logic [31:0] eq, er, dm;
    logic eo;
    int lat, n;
    n = 32 - 2 * s;
    dm = hm ? (d & 32'h0000FFFF) : d;
    model(x, dm, n, eq, er, eo);
    @(negedge clk);
    dvd = x; dvs = d; sel = s; half = hm; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    chk("R3 busy after start", {31'd0, busy}, 32'd1);
    while (!done && lat < 100) begin
      if (inject && lat == 2) begin
        dvd = ~x; dvs = d ^ 32'h00F0_0F01; sel = 4'd15; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    chk(inject ? "R5 latency with start while busy" : "R2 R3 latency", lat, n + 1);
    chk("R3 idle at done", {31'd0, busy}, 32'd0);
    chk(inject ? "R5 quotient" : (hm ? "R10 quotient" : "R6 quotient"), quo, eq);
    chk(inject ? "R5 remainder" : "R7 remainder", rem, er);
    chk("R9 overflow", {31'd0, ovf}, {31'd0, eo});
    @(negedge clk);
    chk("R4 done single cycle", {31'd0, done}, 32'd0);
    chk("R4 quotient held", quo, eq);
  endtask

  task automatic check_math(input logic [31:0] x, input logic [31:0] d);
    run_div(x, d, 4'd0, 1'b0, 1'b0);
    chk("R11 integer quotient", quo, x / d);
    chk("R11 integer remainder", rem, x % d);
    chk("R11 no overflow", {31'd0, ovf}, 32'd0);
  endtask

  initial begin
    logic [31:0] hq, hr;
    logic [31:0] x, d;
    logic [3:0] s;
    logic hm;
    void'($urandom(32'h5EED_1234));
    repeat (4) @(negedge clk);
    chk("R1 busy reset", {31'd0, busy}, 32'd0);
    chk("R1 done reset", {31'd0, done}, 32'd0);
    chk("R1 quotient reset", quo, 32'd0);
    chk("R1 remainder reset", rem, 32'd0);
    chk("R1 overflow reset", {31'd0, ovf}, 32'd0);
    rst_n = 1'b1;

    check_math(32'd100, 32'd7);
    check_math(32'd65535, 32'd1);
    check_math(32'h7FFF_FFFF, 32'h0000_FFFF);
    check_math(32'd5, 32'd9);

    run_div(32'h1234_5678, 32'd0, 4'd0, 1'b0, 1'b0);
    chk("R8 zero divisor overflow", {31'd0, ovf}, 32'd1);
    run_div(32'h0000_0F00, 32'd0, 4'd7, 1'b0, 1'b0);
    chk("R8 zero divisor overflow N=18", {31'd0, ovf}, 32'd1);
    run_div(32'hFFFF_0000, 32'hABCD_0000, 4'd8, 1'b1, 1'b0);
    chk("R8 halfword zero divisor overflow", {31'd0, ovf}, 32'd1);

    run_div(32'hC000_0000, 32'd3, 4'd15, 1'b0, 1'b0);
    run_div(32'h8000_0000, 32'd1, 4'd15, 1'b0, 1'b0);
    run_div(32'hFFFF_FFFF, 32'd1, 4'd0, 1'b0, 1'b0);
    run_div(32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'd0, 1'b0, 1'b0);

    // R10: upper divisor bits must not matter in halfword mode
    run_div(32'd1000, 32'hABCD_0005, 4'd0, 1'b1, 1'b0);
    hq = quo; hr = rem;
    run_div(32'd1000, 32'h0000_0005, 4'd0, 1'b1, 1'b0);
    chk("R10 quotient independent of upper bits", hq, quo);
    chk("R10 remainder independent of upper bits", hr, rem);
    chk("R10 halfword quotient", quo, 32'd200);

    // R5: start while busy is ignored
    run_div(32'h0123_4567, 32'd77, 4'd6, 1'b0, 1'b1);
    run_div(32'h00FF_0000, 32'd300, 4'd4, 1'b1, 1'b1);

    // R4: outputs hold after completion
    hq = quo; hr = rem;
    repeat (5) @(negedge clk);
    chk("R4 quotient held while idle", quo, hq);
    chk("R4 remainder held while idle", rem, hr);
    chk("R4 done stays low", {31'd0, done}, 32'd0);

    for (int i = 0; i < 200; i++) begin
      x = $urandom();
      d = $urandom();
      if (i % 3 == 0) d = d >> ($urandom() % 32);
      if (i % 17 == 0) d = 32'd0;
      s = 4'($urandom() % 16);
      hm = 1'($urandom() % 2);
      run_div(x, d, s, hm, 1'b0);
    end
    for (int i = 0; i < 20; i++) begin
      x = $urandom() & 32'h7FFF_FFFF;
      d = ($urandom() % 32'hFFFF) + 32'd1;
      check_math(x, d);
    end
    wrap_up();
  end

endmodule